// File: doc/BRIEF.md
# USB 2.0 Host Interrupt Enable and Threshold Unit

This block turns event pulses from a USB 2.0 host controller core into a single level-sensitive interrupt request. Six event sources each latch a status flag. A 32-bit enable register chooses which of those flags may drive the request. A flag whose enable is clear still latches, so software can poll it.

Three sources are deferred: transfer complete, transfer error and asynchronous-schedule advance. Their flags reach the request only after the next interrupt threshold boundary. A counter of microframe ticks marks these boundaries at a programmable spacing. The other three sources act at once: port change, frame list rollover and host system error. Software acknowledges a source by writing a one to its status bit.

The block has a small register bus: word address, write data, a write strobe and combinational read data. The interrupt request is its only other output.

Top module: `usb_host_irq_unit`

## Requirements
- R1: Register map by word address: 0 = status, 1 = enable, 2 = threshold code, any other address reads zero. In both the status and the enable register, bit 0 is transfer complete, bit 1 transfer error, bit 2 port change, bit 3 frame list rollover, bit 4 host system error and bit 5 async advance. Enable bits 31..6 always read zero and ignore writes.
- R2: After reset the status register, the enable register and irq_o are zero, and the threshold code reads 3.
- R3: irq_o is asserted only if at least one source has both its enable bit and its status bit set.
- R4: An event pulse sets its status bit whether or not the source is enabled, and software can read that bit.
- R5: Deferred sources (bits 0, 1 and 5) assert irq_o only after a threshold boundary that occurs while their status is set. irq_o rises one clock after the boundary edge.
- R6: Immediate sources (bits 2, 3 and 4) need no boundary. irq_o rises on the clock edge after the edge that samples the event.
- R7: Writing a one to a status bit clears it, and writing a zero leaves it unchanged.
- R8: An event and a clear of the same status bit in the same cycle leave the bit set.
- R9: Threshold code c (0..6) places a boundary on every 2^c-th microframe tick. Code 7 behaves as 6. Writing the code restarts the tick count.
- R10: irq_o is a registered level and stays high while an enabled source is still active. Clearing that enable bit drops irq_o one clock later.
- R11: Clearing the status of the only active source drops irq_o one clock after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | One-cycle event pulses, one per source, same bit order as status |
| uframe_tick_i | input | 1 | One-cycle pulse at each microframe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt request to the host |

## Verification
Every source is pulsed alone, once with its enable set and once with it clear. This separates the status latch from the enable gate, and the deferred path from the immediate one. All eight threshold codes are run with one deferred source, and the bench counts ticks up to the boundary. The point where irq_o rises shows whether the interval is the power of two and whether code 7 clamps. Directed cases then apply an event and a clear in the same cycle, write zeros to status, and drop an enable while its status is held. These cases tell apart event priority, write-one-to-clear behaviour and the one-cycle drop of the level.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Decode a word address into a register select.
  function automatic reg_sel_e decode_addr(input logic [7:0] addr);
    case (addr)
      8'd0:    return SEL_STATUS;
      8'd1:    return SEL_ENABLE;
      8'd2:    return SEL_THRESH;
      default: return SEL_NONE;
    endcase
  endfunction

  // Ticks between boundaries for a code, with codes above max_code clamped.
  function automatic int unsigned thr_span(input int unsigned code,
                                           input int unsigned max_code);
    int unsigned c;
    c = (code > max_code) ? max_code : code;
    return 32'd1 << c;
  endfunction

  // Status bits after one cycle: a hardware event outranks a software clear.
  function automatic logic [7:0] next_status(input logic [7:0] cur,
                                             input logic [7:0] evt,
                                             input logic [7:0] clr);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/irq_thr_timer.sv
module irq_thr_timer
  import usb_irq_pkg::*;
#(
  parameter int MAX_CODE   = 6,
  parameter int THR_W      = 3,
  parameter int RESET_CODE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [THR_W-1:0] cfg_code_i,
  output logic [THR_W-1:0] code_o,
  output logic             boundary_o
);
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [THR_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt   = CNT_W'(thr_span(32'(code_q), 32'(MAX_CODE)) - 1);
    boundary_o = tick_i && (cnt_q >= last_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= THR_W'(RESET_CODE);
      cnt_q  <= '0;
    end else if (cfg_we_i) begin
      code_q <= cfg_code_i;
      cnt_q  <= '0;
    end else if (boundary_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import usb_irq_pkg::*;
#(
  parameter int              SRC_N      = 6,
  parameter logic [SRC_N-1:0] DEFER_MASK = 6'b100011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] clr_i,
  input  logic             boundary_i,
  output logic [SRC_N-1:0] sts_o,
  output logic [SRC_N-1:0] rel_o
);
  logic [SRC_N-1:0] sts_q;
  logic [SRC_N-1:0] sts_d;

  always_comb begin
    sts_d = SRC_N'(next_status(8'(sts_q), 8'(evt_i), 8'(clr_i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_src
      if (DEFER_MASK[g]) begin : g_defer
        logic rel_q;
        always_ff @(posedge clk) begin
          if (!rst_n) rel_q <= 1'b0;
          else        rel_q <= ((rel_q && !clr_i[g]) || (boundary_i && sts_q[g])) && sts_d[g];
        end
        assign rel_o[g] = rel_q;
      end else begin : g_imm
        assign rel_o[g] = 1'b1;
      end
    end
  endgenerate

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int SRC_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we_i,
  input  logic [SRC_N-1:0] en_wdata_i,
  input  logic [SRC_N-1:0] sts_i,
  input  logic [SRC_N-1:0] rel_i,
  output logic [SRC_N-1:0] en_o,
  output logic             irq_o
);
  logic [SRC_N-1:0] en_q;
  logic             irq_q;
  logic             irq_d;

  always_comb irq_d = |(sts_i & rel_i & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      irq_q <= irq_d;
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/usb_host_irq_unit.sv
module usb_host_irq_unit
  import usb_irq_pkg::*;
#(
  parameter int               ADDR_W     = 4,
  parameter int               DATA_W     = 32,
  parameter int               SRC_N      = 6,
  parameter int               MAX_CODE   = 6,
  parameter int               THR_W      = 3,
  parameter int               RESET_CODE = 3,
  parameter logic [SRC_N-1:0] DEFER_MASK = 6'b100011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              uframe_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  reg_sel_e         sel_w;
  logic             sts_we_w;
  logic             en_we_w;
  logic             thr_we_w;
  logic [SRC_N-1:0] clr_w;
  logic [SRC_N-1:0] sts_w;
  logic [SRC_N-1:0] rel_w;
  logic [SRC_N-1:0] en_w;
  logic [THR_W-1:0] code_w;
  logic             boundary_w;
  logic             unused_wdata;

  always_comb begin
    sel_w    = decode_addr(8'(reg_addr_i));
    sts_we_w = reg_we_i && (sel_w == SEL_STATUS);
    en_we_w  = reg_we_i && (sel_w == SEL_ENABLE);
    thr_we_w = reg_we_i && (sel_w == SEL_THRESH);
    clr_w    = sts_we_w ? reg_wdata_i[SRC_N-1:0] : '0;
  end

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:SRC_N];

  irq_thr_timer #(
    .MAX_CODE  (MAX_CODE),
    .THR_W     (THR_W),
    .RESET_CODE(RESET_CODE)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (uframe_tick_i),
    .cfg_we_i  (thr_we_w),
    .cfg_code_i(reg_wdata_i[THR_W-1:0]),
    .code_o    (code_w),
    .boundary_o(boundary_w)
  );

  irq_status_bank #(
    .SRC_N     (SRC_N),
    .DEFER_MASK(DEFER_MASK)
  ) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_i     (clr_w),
    .boundary_i(boundary_w),
    .sts_o     (sts_w),
    .rel_o     (rel_w)
  );

  irq_combiner #(
    .SRC_N(SRC_N)
  ) comb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_we_i   (en_we_w),
    .en_wdata_i(reg_wdata_i[SRC_N-1:0]),
    .sts_i     (sts_w),
    .rel_i     (rel_w),
    .en_o      (en_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (sel_w)
      SEL_STATUS: reg_rdata_o = DATA_W'(sts_w);
      SEL_ENABLE: reg_rdata_o = DATA_W'(en_w);
      SEL_THRESH: reg_rdata_o = DATA_W'(code_w);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker #(
  parameter int               ADDR_W     = 4,
  parameter int               DATA_W     = 32,
  parameter int               SRC_N      = 6,
  parameter logic [SRC_N-1:0] DEFER_MASK = 6'b100011
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  evt_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [SRC_N-1:0]  sts_w,
  input logic [SRC_N-1:0]  rel_w,
  input logic [SRC_N-1:0]  en_w,
  input logic              boundary_w
);
  localparam logic [SRC_N-1:0] IMM_MASK = ~DEFER_MASK;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DATA_W-1:SRC_N] == '0);

  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(en_w & sts_w)));

  p_event_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((sts_w & $past(evt_i)) == $past(evt_i)));

  p_release_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_w |=> ((rel_w & ~$past(rel_w)) == '0));

  p_immediate_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_w & sts_w & IMM_MASK)) |=> irq_o);

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == '0) |=>
      ((sts_w & $past(reg_wdata_i[SRC_N-1:0] & ~evt_i)) == '0));
endmodule

bind usb_host_irq_unit irq_unit_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .SRC_N     (SRC_N),
  .DEFER_MASK(DEFER_MASK)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_we_i   (reg_we_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .sts_w      (sts_w),
  .rel_w      (rel_w),
  .en_w       (en_w),
  .boundary_w (boundary_w)
);

// File: tb/usb_host_irq_unit_tb_top.sv
module usb_host_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic        tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_host_irq_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .uframe_tick_i(tick),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_we_i     (we),
    .reg_rdata_o  (rdata),
    .irq_o        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [5:0] m);
    evt = m;
    step();
    evt = '0;
  endtask

  task automatic utick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  function automatic bit is_deferred(input int k);
    return (k == 0) || (k == 1) || (k == 5);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    chk("R2 irq after reset", 32'(irq), 0);
    rd(0, v); chk("R2 status after reset", v, 0);
    rd(1, v); chk("R2 enable after reset", v, 0);
    rd(2, v); chk("R2 threshold after reset", v, 3);

    // R1: reserved enable bits and unmapped address
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R1 enable reserved bits", v, 32'h3F);
    rd(3, v); chk("R1 unmapped address", v, 0);
    wr(1, 0);

    // Source sweep: each bit, enabled and disabled, threshold code 0
    wr(2, 0);
    for (int k = 0; k < 6; k++) begin
      for (int e = 0; e < 2; e++) begin
        wr(0, 32'h3F);
        wr(1, e ? (32'd1 << k) : 0);
        step();
        pulse(6'(1 << k));
        rd(0, v); chk("R4 status latched", v, 32'd1 << k);
        if (is_deferred(k)) begin
          step(); chk("R5 deferred waits for boundary", 32'(irq), 0);
          utick(); chk("R5 not yet at boundary edge", 32'(irq), 0);
          step(); chk("R5/R3 after boundary", 32'(irq), 32'(e));
        end else begin
          step(); chk("R6/R3 immediate source", 32'(irq), 32'(e));
        end
        wr(0, 32'd1 << k);
        rd(0, v); chk("R7 write one clears", v, 0);
        step(); chk("R11 irq drops after clear", 32'(irq), 0);
      end
    end
    wr(1, 0);

    // R7: writing zeros leaves status unchanged
    wr(0, 32'h3F);
    pulse(6'b000100);
    wr(0, 0);
    rd(0, v); chk("R7 write zero no effect", v, 32'h4);

    // R8: event and clear in the same cycle
    wr(0, 32'h3F);
    evt = 6'b000100; addr = 0; wdata = 32'h4; we = 1'b1;
    step();
    evt = '0; we = 1'b0; wdata = '0;
    rd(0, v); chk("R8 event beats clear", v, 32'h4);
    wr(0, 32'h3F);

    // R10: level output and enable drop
    wr(1, 32'h3F);
    pulse(6'b001000);
    step(); chk("R10 irq set", 32'(irq), 1);
    step(); step(); chk("R10 irq stays at level", 32'(irq), 1);
    wr(1, 0);
    chk("R10 irq still registered", 32'(irq), 1);
    step(); chk("R10 irq drops after disable", 32'(irq), 0);
    wr(0, 32'h3F);

    // R9: threshold interval sweep including clamped code 7
    wr(1, 32'h1);
    for (int c = 0; c < 8; c++) begin
      int n;
      n = 1 << ((c > 6) ? 6 : c);
      wr(0, 32'h3F);
      wr(2, 32'(c));
      rd(2, v); chk("R9 code readback", v, 32'(c));
      pulse(6'b000001);
      for (int t = 0; t < n - 1; t++) utick();
      step(); chk("R9 no irq before interval end", 32'(irq), 0);
      utick(); step(); chk("R9 irq at interval end", 32'(irq), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule